// File: doc/BRIEF.md
# Multithreaded Unified Shader Thread Scheduler

This block keeps a pool of thread slots that share one SIMD arithmetic pipe. The pipe serves vertex, triangle-setup and fragment work alike. Each slot holds one thread. A thread is a group of four elements of one kind, and its four element values are packed side by side in each 128-bit temporary register. The slot records the kind of work, a program counter, the counter value at which the program ends, and a short latency countdown. Work of every kind is drawn from the same pool, with no slots reserved for any kind.

A new thread enters through a request port, and the request takes the lowest-numbered free slot. Each cycle one ready thread is picked in rotating order and one instruction is sent to the arithmetic pipe. The pipe is a stand-in with a fixed latency. It reads the temporary register selected by the low bits of the program counter and writes that value plus one back into the same register. When the write-back of the final instruction returns, the slot is released and a completion pulse reports the slot number and the kind. External ports can write and read any register of any slot, so that inputs can be loaded and results collected.

Top module: `shader_thread_sched`

## Requirements
- R1: During and after reset no slot is occupied. `new_ready` is 1, `new_slot` is 0, and `iss_valid` and `done_valid` are 0. All registers of all slots read as zero.
- R2: A request is accepted in a cycle where `new_valid` and `new_ready` are both 1. It takes the slot shown on `new_slot`, which is always the lowest-numbered free slot.
- R3: While all 16 slots are occupied, `new_ready` is 0 and a held request is not taken. `new_ready` returns only after a completion pulse. The held request then goes into the slot that completed.
- R4: Among the ready slots, the one issued is the first found when searching upward from the slot after the last issuer, wrapping past the highest slot. It is not simply the lowest-numbered ready slot.
- R5: A slot that issues is not ready for the next 4 cycles. A slot running alone therefore issues every 5 cycles, and other slots may issue in between.
- R6: The first issue of a thread carries the program counter given at request time. Each later issue of that thread carries a value one higher.
- R7: An instruction whose program counter equals the thread's end value is its last. Exactly 4 cycles after it issues, `done_valid` pulses for one cycle with that slot and its kind. The slot is free in the following cycle.
- R8: Each slot has 16 private registers of 128 bits. A write through `wr_*` shows on `rd_data` from the next cycle. Writes to one slot leave every other slot's registers unchanged.
- R9: Each issue reads register (program counter mod 16) of its slot. The write-back, 4 cycles later, stores that value plus one into the same register.
- R10: Kind codes are 0 vertex, 1 triangle and 2 fragment. `iss_kind` and `done_kind` report the code given with the request, for any mix of kinds in the pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| new_valid | input | 1 | Thread request present |
| new_kind | input | 2 | Kind code of the requested thread |
| new_pc | input | 8 | First program counter value |
| new_end_pc | input | 8 | Program counter value of the last instruction |
| new_ready | output | 1 | A free slot exists |
| new_slot | output | 4 | Slot that an accepted request takes |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_slot | output | 4 | Issuing slot |
| iss_kind | output | 2 | Kind of the issuing slot |
| iss_pc | output | 8 | Program counter of the issued instruction |
| done_valid | output | 1 | Final write-back of a thread |
| done_slot | output | 4 | Slot that completed |
| done_kind | output | 2 | Kind of the completed thread |
| wr_en | input | 1 | External register write |
| wr_slot | input | 4 | Slot of the external write |
| wr_idx | input | 4 | Register index of the external write |
| wr_data | input | 128 | External write data |
| rd_slot | input | 4 | Slot of the external read |
| rd_idx | input | 4 | Register index of the external read |
| rd_data | output | 128 | External read data, combinational |

## Verification
The bench first runs a single thread by itself, which shows the bare 5-cycle issue spacing, the program counter stepping and the 4-cycle completion delay with no competition. It then staggers three requests of different kinds so that two slots become ready in the same cycle just after a middle slot has issued. This pattern separates a rotating pick from a lowest-index pick. Filling all sixteen slots and holding a seventeenth request tests backpressure, reuse of the freed slot, and the absence of lost or duplicated threads under full contention. Register reads after each run show how the write-back stand-in and the external port act on each slot.

// File: rtl/sts_pkg.sv
package sts_pkg;

    typedef enum logic [1:0] {
        KIND_VERT = 2'd0,
        KIND_TRI  = 2'd1,
        KIND_FRAG = 2'd2,
        KIND_RSVD = 2'd3
    } kind_e;

endpackage

// File: rtl/sts_pick.sv
// Rotating ready pick and lowest free-slot search.
module sts_pick #(
    parameter int N  = 16,
    parameter int SW = $clog2(N)
) (
    input  logic [N-1:0]  ready,
    input  logic [N-1:0]  free,
    input  logic [SW-1:0] last,
    output logic          any_rdy,
    output logic [SW-1:0] pick,
    output logic          any_free,
    output logic [SW-1:0] free_idx
);
    always_comb begin
        any_rdy = 1'b0;
        pick    = '0;
        // descending offset so the nearest candidate after 'last' wins
        for (int off = N; off >= 1; off--) begin
            int idx;
            idx = (int'(last) + off) % N;
            if (ready[idx]) begin
                any_rdy = 1'b1;
                pick    = SW'(idx);
            end
        end
    end

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free[i]) begin
                any_free = 1'b1;
                free_idx = SW'(i);
            end
        end
    end
endmodule

// File: rtl/sts_alu_pipe.sv
// Fixed-latency stand-in for the SIMD ALU: returns operand + 1 as write-back.
module sts_alu_pipe #(
    parameter int LAT  = 4,
    parameter int SW   = 4,
    parameter int IW   = 4,
    parameter int DW   = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [SW-1:0] in_slot,
    input  logic [IW-1:0] in_idx,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    output logic          out_vld,
    output logic [SW-1:0] out_slot,
    output logic [IW-1:0] out_idx,
    output logic [DW-1:0] out_data,
    output logic          out_last
);
    logic          vld_q  [LAT];
    logic [SW-1:0] slot_q [LAT];
    logic [IW-1:0] idx_q  [LAT];
    logic [DW-1:0] data_q [LAT];
    logic          last_q [LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < LAT; s++) begin
                vld_q[s]  <= 1'b0;
                slot_q[s] <= '0;
                idx_q[s]  <= '0;
                data_q[s] <= '0;
                last_q[s] <= 1'b0;
            end
        end else begin
            vld_q[0]  <= in_vld;
            slot_q[0] <= in_slot;
            idx_q[0]  <= in_idx;
            data_q[0] <= in_data + DW'(1);
            last_q[0] <= in_last;
            for (int s = 1; s < LAT; s++) begin
                vld_q[s]  <= vld_q[s-1];
                slot_q[s] <= slot_q[s-1];
                idx_q[s]  <= idx_q[s-1];
                data_q[s] <= data_q[s-1];
                last_q[s] <= last_q[s-1];
            end
        end
    end

    assign out_vld  = vld_q[LAT-1];
    assign out_slot = slot_q[LAT-1];
    assign out_idx  = idx_q[LAT-1];
    assign out_data = data_q[LAT-1];
    assign out_last = last_q[LAT-1];
endmodule

// File: rtl/sts_regfile.sv
// Per-slot temporary registers: ALU write port wins over external write.
module sts_regfile #(
    parameter int N  = 16,
    parameter int R  = 16,
    parameter int DW = 128,
    parameter int SW = $clog2(N),
    parameter int IW = $clog2(R)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alu_we,
    input  logic [SW-1:0] alu_slot,
    input  logic [IW-1:0] alu_idx,
    input  logic [DW-1:0] alu_data,
    input  logic          ext_we,
    input  logic [SW-1:0] ext_slot,
    input  logic [IW-1:0] ext_idx,
    input  logic [DW-1:0] ext_data,
    input  logic [SW-1:0] ra_slot,
    input  logic [IW-1:0] ra_idx,
    output logic [DW-1:0] ra_data,
    input  logic [SW-1:0] rb_slot,
    input  logic [IW-1:0] rb_idx,
    output logic [DW-1:0] rb_data
);
    localparam int DEPTH = N * R;

    logic [DW-1:0] mem_q [DEPTH];

    function automatic int addr_of(input logic [SW-1:0] s, input logic [IW-1:0] i);
        return int'(s) * R + int'(i);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
        end else begin
            if (ext_we) mem_q[addr_of(ext_slot, ext_idx)] <= ext_data;
            if (alu_we) mem_q[addr_of(alu_slot, alu_idx)] <= alu_data;
        end
    end

    assign ra_data = mem_q[addr_of(ra_slot, ra_idx)];
    assign rb_data = mem_q[addr_of(rb_slot, rb_idx)];
endmodule

// File: rtl/shader_thread_sched.sv
module shader_thread_sched #(
    parameter int N_SLOTS = 16,
    parameter int N_REGS  = 16,
    parameter int REG_W   = 128,
    parameter int PC_W    = 8,
    parameter int ALU_LAT = 4,
    localparam int SW = $clog2(N_SLOTS),
    localparam int IW = $clog2(N_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             new_valid,
    input  logic [1:0]       new_kind,
    input  logic [PC_W-1:0]  new_pc,
    input  logic [PC_W-1:0]  new_end_pc,
    output logic             new_ready,
    output logic [SW-1:0]    new_slot,
    output logic             iss_valid,
    output logic [SW-1:0]    iss_slot,
    output logic [1:0]       iss_kind,
    output logic [PC_W-1:0]  iss_pc,
    output logic             done_valid,
    output logic [SW-1:0]    done_slot,
    output logic [1:0]       done_kind,
    input  logic             wr_en,
    input  logic [SW-1:0]    wr_slot,
    input  logic [IW-1:0]    wr_idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic [SW-1:0]    rd_slot,
    input  logic [IW-1:0]    rd_idx,
    output logic [REG_W-1:0] rd_data
);
    import sts_pkg::*;

    localparam int CW = $clog2(ALU_LAT + 1);

    typedef struct packed {
        logic  [N_SLOTS-1:0]           vld;
        kind_e [N_SLOTS-1:0]           kind;
        logic  [N_SLOTS-1:0][PC_W-1:0] pc;
        logic  [N_SLOTS-1:0][PC_W-1:0] end_pc;
        logic  [N_SLOTS-1:0][CW-1:0]   cnt;
        logic  [SW-1:0]                last;
    } sched_t;

    sched_t st_q, st_d;

    logic [N_SLOTS-1:0] slot_rdy;
    logic               any_rdy, any_free;
    logic [SW-1:0]      pick, free_idx;
    logic [REG_W-1:0]   opnd;
    logic               wb_vld, wb_last;
    logic [SW-1:0]      wb_slot;
    logic [IW-1:0]      wb_idx;
    logic [REG_W-1:0]   wb_data;
    logic               iss_is_last;

    always_comb begin
        for (int i = 0; i < N_SLOTS; i++) begin
            slot_rdy[i] = st_q.vld[i] && (st_q.cnt[i] == '0);
        end
    end

    sts_pick #(.N(N_SLOTS), .SW(SW)) u_pick (
        .ready    (slot_rdy),
        .free     (~st_q.vld),
        .last     (st_q.last),
        .any_rdy  (any_rdy),
        .pick     (pick),
        .any_free (any_free),
        .free_idx (free_idx)
    );

    assign iss_valid   = any_rdy;
    assign iss_slot    = pick;
    assign iss_kind    = st_q.kind[pick];
    assign iss_pc      = st_q.pc[pick];
    assign iss_is_last = (st_q.pc[pick] == st_q.end_pc[pick]);

    sts_regfile #(.N(N_SLOTS), .R(N_REGS), .DW(REG_W), .SW(SW), .IW(IW)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .alu_we   (wb_vld),
        .alu_slot (wb_slot),
        .alu_idx  (wb_idx),
        .alu_data (wb_data),
        .ext_we   (wr_en),
        .ext_slot (wr_slot),
        .ext_idx  (wr_idx),
        .ext_data (wr_data),
        .ra_slot  (rd_slot),
        .ra_idx   (rd_idx),
        .ra_data  (rd_data),
        .rb_slot  (pick),
        .rb_idx   (st_q.pc[pick][IW-1:0]),
        .rb_data  (opnd)
    );

    sts_alu_pipe #(.LAT(ALU_LAT), .SW(SW), .IW(IW), .DW(REG_W)) u_alu (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (any_rdy),
        .in_slot  (pick),
        .in_idx   (st_q.pc[pick][IW-1:0]),
        .in_data  (opnd),
        .in_last  (iss_is_last),
        .out_vld  (wb_vld),
        .out_slot (wb_slot),
        .out_idx  (wb_idx),
        .out_data (wb_data),
        .out_last (wb_last)
    );

    always_comb begin
        st_d = st_q;
        // latency countdown for every slot
        for (int i = 0; i < N_SLOTS; i++) begin
            if (st_q.cnt[i] != '0) st_d.cnt[i] = st_q.cnt[i] - CW'(1);
        end
        // issue
        if (any_rdy) begin
            st_d.pc[pick]  = st_q.pc[pick] + PC_W'(1);
            st_d.cnt[pick] = CW'(ALU_LAT);
            st_d.last      = pick;
        end
        // allocation into the lowest free slot
        if (new_valid && any_free) begin
            st_d.vld[free_idx]    = 1'b1;
            st_d.kind[free_idx]   = kind_e'(new_kind);
            st_d.pc[free_idx]     = new_pc;
            st_d.end_pc[free_idx] = new_end_pc;
            st_d.cnt[free_idx]    = '0;
        end
        // retirement on final write-back
        if (wb_vld && wb_last) begin
            st_d.vld[wb_slot] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign new_ready  = any_free;
    assign new_slot   = free_idx;
    assign done_valid = wb_vld && wb_last;
    assign done_slot  = wb_slot;
    assign done_kind  = st_q.kind[wb_slot];
endmodule

// File: rtl/sts_checker.sv
module sts_checker #(
    parameter int SW   = 4,
    parameter int PC_W = 8,
    parameter int LAT  = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            new_valid,
    input logic            new_ready,
    input logic [SW-1:0]   new_slot,
    input logic            iss_valid,
    input logic [SW-1:0]   iss_slot,
    input logic [1:0]      iss_kind,
    input logic [PC_W-1:0] iss_pc,
    input logic            done_valid,
    input logic [SW-1:0]   done_slot,
    input logic [1:0]      done_kind
);
    AST_ALLOC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (new_valid && new_ready) |=> (new_slot != $past(new_slot))); // R2

    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(new_ready) |-> $past(done_valid)); // R3

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> !(iss_valid && (iss_slot == $past(iss_slot)))); // R5

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> ($past(iss_valid, LAT) && ($past(iss_slot, LAT) == done_slot))); // R7

    AST_DONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_kind == $past(iss_kind, LAT))); // R10
endmodule

bind shader_thread_sched sts_checker #(.SW(SW), .PC_W(PC_W), .LAT(ALU_LAT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .new_valid  (new_valid),
    .new_ready  (new_ready),
    .new_slot   (new_slot),
    .iss_valid  (iss_valid),
    .iss_slot   (iss_slot),
    .iss_kind   (iss_kind),
    .iss_pc     (iss_pc),
    .done_valid (done_valid),
    .done_slot  (done_slot),
    .done_kind  (done_kind)
);

// File: tb/shader_thread_sched_bench.sv
module shader_thread_sched_bench;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         new_valid = 1'b0;
    logic [1:0]   new_kind = '0;
    logic [7:0]   new_pc = '0;
    logic [7:0]   new_end_pc = '0;
    logic         new_ready;
    logic [3:0]   new_slot;
    logic         iss_valid;
    logic [3:0]   iss_slot;
    logic [1:0]   iss_kind;
    logic [7:0]   iss_pc;
    logic         done_valid;
    logic [3:0]   done_slot;
    logic [1:0]   done_kind;
    logic         wr_en = 1'b0;
    logic [3:0]   wr_slot = '0;
    logic [3:0]   wr_idx = '0;
    logic [127:0] wr_data = '0;
    logic [3:0]   rd_slot = '0;
    logic [3:0]   rd_idx = '0;
    logic [127:0] rd_data;

    int tests = 0;
    int fails = 0;

    int cyc = 0;
    int n_iss = 0;
    int n_done = 0;
    int iss_s [512];
    int iss_p [512];
    int iss_k [512];
    int iss_c [512];
    int dn_s [64];
    int dn_k [64];
    int dn_c [64];

    shader_thread_sched u_shader_thread_sched (
        .clk(clk), .rst_n(rst_n),
        .new_valid(new_valid), .new_kind(new_kind), .new_pc(new_pc), .new_end_pc(new_end_pc),
        .new_ready(new_ready), .new_slot(new_slot),
        .iss_valid(iss_valid), .iss_slot(iss_slot), .iss_kind(iss_kind), .iss_pc(iss_pc),
        .done_valid(done_valid), .done_slot(done_slot), .done_kind(done_kind),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_slot(rd_slot), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    always #(CLK_P/2) clk = ~clk;

    // event log, sampled at the edge (pre-update values)
    always @(posedge clk) begin
        if (rst_n) begin
            if (iss_valid && n_iss < 512) begin
                iss_s[n_iss] = int'(iss_slot);
                iss_p[n_iss] = int'(iss_pc);
                iss_k[n_iss] = int'(iss_kind);
                iss_c[n_iss] = cyc;
                n_iss = n_iss + 1;
            end
            if (done_valid && n_done < 64) begin
                dn_s[n_done] = int'(done_slot);
                dn_k[n_done] = int'(done_kind);
                dn_c[n_done] = cyc;
                n_done = n_done + 1;
            end
        end
        cyc = cyc + 1;
    end

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_done(input int target);
        for (int k = 0; k < 3000 && n_done < target; k++) tick();
        chk("R7", "completion count reached", 128'(n_done), 128'(target));
    endtask

    task automatic read_reg(input int s, input int i, output logic [127:0] v);
        rd_slot = 4'(s);
        rd_idx  = 4'(i);
        #1;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [127:0] v;
        rst_n = 1'b0;
        repeat (3) tick();
        chk("R1", "ready in reset", 128'(new_ready), 128'(1));
        rst_n = 1'b1;
        tick();
        chk("R1", "ready after reset", 128'(new_ready), 128'(1));
        chk("R1", "new_slot after reset", 128'(new_slot), 128'(0));
        chk("R1", "no issue after reset", 128'(iss_valid), 128'(0));
        chk("R1", "no done after reset", 128'(done_valid), 128'(0));
        read_reg(7, 9, v);
        chk("R1", "register zero after reset", v, 128'(0));
    endtask

    task automatic t_regs();
        logic [127:0] v;
        logic [127:0] a_val;
        logic [127:0] b_val;
        a_val = {64'hDEAD_BEEF_0123_4567, 64'h89AB_CDEF_F00D_CAFE};
        b_val = {64'h0F0F_0F0F_1234_5678, 64'hA5A5_5A5A_0000_0001};
        read_reg(5, 12, v);
        chk("R8", "untouched register", v, 128'(0));
        wr_en = 1'b1; wr_slot = 4'd3; wr_idx = 4'd12; wr_data = a_val;
        tick();
        wr_slot = 4'd4; wr_data = b_val;
        tick();
        wr_en = 1'b0;
        read_reg(3, 12, v);
        chk("R8", "slot3 reg12", v, a_val);
        read_reg(4, 12, v);
        chk("R8", "slot4 reg12 isolated", v, b_val);
        read_reg(3, 13, v);
        chk("R8", "slot3 reg13 unchanged", v, 128'(0));
    endtask

    task automatic t_single();
        int bi;
        int bd;
        logic [127:0] v;
        logic [127:0] x_val;
        bi = n_iss;
        bd = n_done;
        x_val = {64'h1111_2222_3333_4444, 64'h5555_6666_7777_00FF};
        wr_en = 1'b1; wr_slot = 4'd0; wr_idx = 4'd2; wr_data = x_val;
        tick();
        wr_en = 1'b0;
        new_valid = 1'b1; new_kind = 2'd2; new_pc = 8'd2; new_end_pc = 8'd4;
        #1;
        chk("R2", "ready with free slots", 128'(new_ready), 128'(1));
        chk("R2", "lowest free slot", 128'(new_slot), 128'(0));
        tick();
        new_valid = 1'b0;
        #1;
        chk("R2", "next free slot after accept", 128'(new_slot), 128'(1));
        wait_done(bd + 1);
        chk("R6", "issue count", 128'(n_iss - bi), 128'(3));
        for (int k = 0; k < 3; k++) begin
            chk("R6", "pc sequence", 128'(iss_p[bi + k]), 128'(2 + k));
            chk("R10", "issue kind fragment", 128'(iss_k[bi + k]), 128'(2));
        end
        chk("R5", "spacing 1", 128'(iss_c[bi + 1] - iss_c[bi]), 128'(5));
        chk("R5", "spacing 2", 128'(iss_c[bi + 2] - iss_c[bi + 1]), 128'(5));
        chk("R7", "done slot", 128'(dn_s[bd]), 128'(0));
        chk("R7", "done kind", 128'(dn_k[bd]), 128'(2));
        chk("R7", "done delay", 128'(dn_c[bd] - iss_c[bi + 2]), 128'(4));
        chk("R7", "slot freed", 128'(new_slot), 128'(0));
        read_reg(0, 2, v);
        chk("R9", "reg2 incremented", v, x_val + 128'(1));
        read_reg(0, 3, v);
        chk("R9", "reg3 incremented", v, 128'(1));
        read_reg(0, 4, v);
        chk("R9", "reg4 incremented", v, 128'(1));
    endtask

    task automatic t_rr();
        int bi;
        int bd;
        int exp_s [4];
        int exp_p [4];
        int exp_k [4];
        int exp_g [4];
        bi = n_iss;
        bd = n_done;
        exp_s = '{0, 1, 2, 0};
        exp_p = '{10, 20, 30, 11};
        exp_k = '{0, 1, 2, 0};
        exp_g = '{0, 4, 5, 6};
        new_valid = 1'b1; new_kind = 2'd0; new_pc = 8'd10; new_end_pc = 8'd12;
        #1;
        chk("R2", "rr slot A", 128'(new_slot), 128'(0));
        tick();
        new_valid = 1'b0;
        repeat (3) tick();
        new_valid = 1'b1; new_kind = 2'd1; new_pc = 8'd20; new_end_pc = 8'd22;
        #1;
        chk("R2", "rr slot B", 128'(new_slot), 128'(1));
        tick();
        new_kind = 2'd2; new_pc = 8'd30; new_end_pc = 8'd32;
        #1;
        chk("R2", "rr slot C", 128'(new_slot), 128'(2));
        tick();
        new_valid = 1'b0;
        wait_done(bd + 3);
        for (int k = 0; k < 4; k++) begin
            chk("R4", "rotating order slot", 128'(iss_s[bi + k]), 128'(exp_s[k]));
            chk("R4", "rotating order cycle", 128'(iss_c[bi + k] - iss_c[bi]), 128'(exp_g[k]));
            chk("R6", "rr pc", 128'(iss_p[bi + k]), 128'(exp_p[k]));
            chk("R10", "mixed kinds", 128'(iss_k[bi + k]), 128'(exp_k[k]));
        end
        chk("R6", "rr issue total", 128'(n_iss - bi), 128'(9));
    endtask

    task automatic t_fill();
        int bi;
        int bd;
        int viol;
        int waited;
        bi = n_iss;
        bd = n_done;
        for (int i = 0; i < 16; i++) begin
            new_valid = 1'b1; new_kind = 2'(i % 3); new_pc = 8'd0; new_end_pc = 8'd7;
            #1;
            chk("R2", "fill ready", 128'(new_ready), 128'(1));
            chk("R2", "fill slot order", 128'(new_slot), 128'(i));
            tick();
        end
        new_kind = 2'd1;
        #1;
        chk("R3", "full pool blocks", 128'(new_ready), 128'(0));
        waited = 0;
        while (!new_ready && waited < 1000) begin
            tick();
            waited++;
        end
        chk("R3", "one completion before ready", 128'(n_done - bd), 128'(1));
        chk("R3", "held request takes freed slot", 128'(new_slot), 128'(dn_s[bd]));
        tick();
        new_valid = 1'b0;
        wait_done(bd + 17);
        tick();
        chk("R3", "no lost or extra thread", 128'(n_done - bd), 128'(17));
        chk("R6", "total issues", 128'(n_iss - bi), 128'(136));
        viol = 0;
        for (int i = bi + 1; i < n_iss; i++) begin
            for (int j = i - 1; j >= bi; j--) begin
                if (iss_s[j] == iss_s[i]) begin
                    if (iss_c[i] - iss_c[j] < 5) viol++;
                    break;
                end
            end
        end
        chk("R5", "no slot reissued within 4 cycles", 128'(viol), 128'(0));
    endtask

    initial begin
        #(CLK_P * 50000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_regs();
        t_single();
        t_rr();
        t_fill();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule